// File: doc/BRIEF.md
# Queued-Instruction SPI Master

This block is an SPI bus master steered by a queue of small instructions. Each instruction carries a 2-bit operation code, an 8-bit data byte and a 4-bit slave number. Instructions enter a command FIFO through a valid/ready handshake. A sequencer takes them one at a time and drives the serial clock, the outgoing data line and sixteen active-low slave selects, and it samples the incoming data line.

Every executed instruction produces one result entry. The entry holds the slave number, the operation code and a byte, and it leaves through a second valid/ready FIFO. Depending on the operation, the byte is the received data, the transmitted byte or zero. The serial clock period, its idle level and its sampling phase are fixed when the block is elaborated.

Commands stall when either FIFO is full. A consumer that stops draining results therefore throttles the producer without losing any entry.

Top module: `spi_cmd_master`

## Requirements
- R1: While `rst` is high and right after it is released, `ss_n` is all ones, `sclk` sits at the idle level `CPOL`, `res_valid` is low and `cmd_ready` is high.
- R2: A command is taken on a rising `clk` edge where `cmd_valid` and `cmd_ready` are both high. Commands are executed and reported strictly in the order they were taken.
- R3: `cmd_ready` is low whenever the command FIFO holds `WR_DEPTH` entries or the result FIFO holds `RD_DEPTH` entries. With results never drained, exactly `WR_DEPTH + RD_DEPTH` commands are taken.
- R4: Each executed command yields exactly one result (`res_sel`, `res_op`, `res_data`) shown with `res_valid`. The result is removed on a rising edge where `res_valid` and `res_ready` are both high.
- R5: Op code 2'b00 (write): the byte is shifted out on `mosi` most significant bit first, and `res_data` echoes the byte that was sent.
- R6: Op code 2'b01 (read): `mosi` carries zeros, and `res_data` is the eight `miso` bits, first one received in bit 7.
- R7: Op code 2'b10 (exchange): the byte is shifted out as in R5, and `res_data` is the received byte as in R6.
- R8: Op code 2'b11 (null): no serial clock edges occur, all of `ss_n` stays high for at least `CLK_DIV` cycles, and `res_data` is 8'h00.
- R9: During a transfer exactly one `ss_n` bit is low, the bit numbered by the command's slave field. The select stays low between consecutive non-null commands to the same slave and rises before a different slave is selected.
- R10: `sclk` rests at `CPOL` between transfers. Each high phase lasts `CLK_DIV/2` (rounded down) cycles and each low phase the remaining cycles. Data is sampled on the rising edge when `CPOL == CPHA` and on the falling edge otherwise.
- R11: A falling `ss_n` bit leads the first `sclk` edge by at least the length of an idle-level half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_sel | input | 4 | Slave number of the command |
| cmd_op | input | 2 | Operation code (00 write, 01 read, 10 exchange, 11 null) |
| cmd_byte | input | 8 | Data byte to transmit |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| sclk | output | 1 | Serial clock |
| ss_n | output | 16 | Active-low slave selects, at most one low |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from slaves |
| res_sel | output | 4 | Slave number of the result |
| res_op | output | 2 | Operation code of the result |
| res_data | output | 8 | Received, echoed or zero byte |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |

## Verification
The FIFO assertions assume that no write reaches a full FIFO and no read reaches an empty one. The top guarantees the first by gating writes with `cmd_ready` and the second by gating reads with `res_valid`, and the bench drives `cmd_valid` and `res_ready` only in ways that follow those rules. The serial assertions assume a clean synchronous reset at start-up, and the bench applies that reset at time zero. The slave model in the bench changes `miso` only on negative `clk` edges, well away from the sampling edge, so the bytes received match the response queue. Results are drained with a gappy ready pattern and, for one phase, held off completely so that both FIFOs fill.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int SEL_W  = 4;
  localparam int DATA_W = 8;
  localparam int NSS    = 1 << SEL_W;

  typedef enum logic [1:0] {
    OP_WR   = 2'b00,
    OP_RD   = 2'b01,
    OP_RW   = 2'b10,
    OP_NULL = 2'b11
  } op_e;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    op_e               op;
    logic [DATA_W-1:0] data;
  } item_t;

  localparam int ITEM_W = $bits(item_t);
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  assign rdata = mem[rptr];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) push |-> !full);  // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);  // R4
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 5,
  parameter int CPOL    = 0,
  parameter int CPHA    = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  item_t             in_data,
  output logic              in_pop,
  input  logic              out_room,
  output logic              out_push,
  output item_t             out_data,
  output logic              sclk,
  output logic [NSS-1:0]    ss_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int  HI     = CLK_DIV / 2;
  localparam int  LO     = CLK_DIV - HI;
  localparam int  CW     = $clog2(CLK_DIV + 1);
  localparam int  NEDGE  = 2 * DATA_W;
  localparam int  EW     = $clog2(NEDGE + 1);
  localparam bit  IDLE_L = (CPOL != 0);
  localparam bit  CPHA_B = (CPHA != 0);

  typedef enum logic [2:0] {S_IDLE, S_REL, S_START, S_SHIFT, S_DONE} st_e;

  st_e               state;
  item_t             ins;
  logic              act;
  logic [SEL_W-1:0]  act_sel;
  logic [CW-1:0]     cnt;
  logic [EW-1:0]     edges;
  logic [DATA_W-1:0] tx, rx, txb, dbyte;
  logic              sclk_q, mosi_q;
  logic [NSS-1:0]    ss_q;

  function automatic logic [CW-1:0] half_len(input logic lvl);
    return lvl ? CW'(HI) : CW'(LO);
  endfunction

  assign in_pop   = (state == S_IDLE) && in_valid && out_room;
  assign out_push = (state == S_DONE);
  assign txb      = (ins.op == OP_RD) ? '0 : ins.data;

  always_comb begin
    case (ins.op)
      OP_NULL: dbyte = '0;
      OP_WR:   dbyte = ins.data;
      default: dbyte = rx;
    endcase
    out_data = '{sel: ins.sel, op: ins.op, data: dbyte};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      ins     <= '{sel: '0, op: OP_NULL, data: '0};
      act     <= 1'b0;
      act_sel <= '0;
      cnt     <= '0;
      edges   <= '0;
      tx      <= '0;
      rx      <= '0;
      sclk_q  <= IDLE_L;
      mosi_q  <= 1'b0;
      ss_q    <= '1;
    end else begin
      case (state)
        S_IDLE: if (in_pop) begin
          ins <= in_data;
          if (in_data.op == OP_NULL || (act && act_sel != in_data.sel)) begin
            state <= S_REL;
            act   <= 1'b0;
            ss_q  <= '1;
            cnt   <= CW'(CLK_DIV - 1);
          end else begin
            state <= S_START;
          end
        end
        S_REL: begin
          if (cnt == '0) state <= (ins.op == OP_NULL) ? S_DONE : S_START;
          else           cnt   <= cnt - CW'(1);
        end
        S_START: begin
          act     <= 1'b1;
          act_sel <= ins.sel;
          ss_q    <= ~(NSS'(1) << ins.sel);
          cnt     <= half_len(IDLE_L);
          edges   <= '0;
          if (CPHA_B) begin
            tx <= txb;
          end else begin
            mosi_q <= txb[DATA_W-1];
            tx     <= txb << 1;
          end
          state <= S_SHIFT;
        end
        S_SHIFT: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (edges == EW'(NEDGE)) begin
            state <= S_DONE;
          end else begin
            sclk_q <= !sclk_q;
            cnt    <= half_len(!sclk_q) - CW'(1);
            edges  <= edges + EW'(1);
            if (edges[0] == CPHA_B) begin
              rx <= {rx[DATA_W-2:0], miso};
            end else begin
              mosi_q <= tx[DATA_W-1];
              tx     <= tx << 1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign sclk = sclk_q;
  assign ss_n = ss_q;
  assign mosi = mosi_q;

  AST_SS_ONEHOT:  assert property (@(posedge clk) disable iff (rst) $countones(~ss_q) <= 1);  // R9
  AST_SS_HELD:    assert property (@(posedge clk) disable iff (rst)
                    (state == S_SHIFT && $past(state == S_SHIFT)) |-> $stable(ss_q));  // R9
  AST_SCLK_IDLE:  assert property (@(posedge clk) disable iff (rst)
                    (state == S_IDLE) |-> (sclk_q == IDLE_L));  // R10
  AST_PUSH_ROOM:  assert property (@(posedge clk) disable iff (rst) out_push |-> out_room);  // R4
  AST_NULL_QUIET: assert property (@(posedge clk) disable iff (rst)
                    (state == S_DONE && ins.op == OP_NULL) |-> (ss_q == '1));  // R8
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV  = 5,
  parameter int CPOL     = 0,
  parameter int CPHA     = 0,
  parameter int WR_DEPTH = 4,
  parameter int RD_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  output logic              sclk,
  output logic [NSS-1:0]    ss_n,
  output logic              mosi,
  input  logic              miso,
  output logic [SEL_W-1:0]  res_sel,
  output logic [1:0]        res_op,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  input  logic              res_ready
);
  logic              wf_full, wf_empty, rf_full, rf_empty;
  logic              wf_push, eng_pop, eng_push, rf_pop;
  logic [ITEM_W-1:0] wf_q, rf_q;
  item_t             eng_in, eng_out, res_item;

  assign cmd_ready = !wf_full && !rf_full;
  assign wf_push   = cmd_valid && cmd_ready;
  assign rf_pop    = res_valid && res_ready;

  spi_cmd_fifo #(.DEPTH(WR_DEPTH), .W(ITEM_W)) u_cmd_q (
    .clk(clk), .rst(rst),
    .push(wf_push), .wdata({cmd_sel, cmd_op, cmd_byte}),
    .pop(eng_pop), .rdata(wf_q),
    .full(wf_full), .empty(wf_empty)
  );

  assign eng_in = item_t'(wf_q);

  spi_cmd_engine #(.CLK_DIV(CLK_DIV), .CPOL(CPOL), .CPHA(CPHA)) u_eng (
    .clk(clk), .rst(rst),
    .in_valid(!wf_empty), .in_data(eng_in), .in_pop(eng_pop),
    .out_room(!rf_full), .out_push(eng_push), .out_data(eng_out),
    .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso)
  );

  spi_cmd_fifo #(.DEPTH(RD_DEPTH), .W(ITEM_W)) u_res_q (
    .clk(clk), .rst(rst),
    .push(eng_push), .wdata(eng_out),
    .pop(rf_pop), .rdata(rf_q),
    .full(rf_full), .empty(rf_empty)
  );

  assign res_item  = item_t'(rf_q);
  assign res_valid = !rf_empty;
  assign res_sel   = res_item.sel;
  assign res_op    = res_item.op;
  assign res_data  = res_item.data;

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
                     (res_valid && !res_ready) |=> (res_valid && $stable(rf_q)));  // R4
endmodule

// File: tb/test_spi_cmd_master.sv
`timescale 1ns/1ps
module test_spi_cmd_master;
  localparam int P = 5, CPOL = 0, CPHA = 0, WD = 4, RDP = 4;
  localparam int HI = P / 2, LO = P - HI;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0]  cmd_sel = '0, res_sel;
  logic [1:0]  cmd_op = '0, res_op;
  logic [7:0]  cmd_byte = '0, res_data;
  logic        cmd_valid = 1'b0, cmd_ready, sclk, mosi, miso = 1'b0, res_valid, res_ready = 1'b0;
  logic [15:0] ss_n;

  spi_cmd_master #(.CLK_DIV(P), .CPOL(CPOL), .CPHA(CPHA), .WR_DEPTH(WD), .RD_DEPTH(RDP)) i_spi_cmd_master (
    .clk(clk), .rst(rst), .cmd_sel(cmd_sel), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .res_sel(res_sel), .res_op(res_op), .res_data(res_data),
    .res_valid(res_valid), .res_ready(res_ready)
  );

  int total = 0, bad = 0, n_acc = 0, waits = 0, ss_rises = 0, cyc = 0;
  bit rr_hold = 1'b0;
  logic [13:0] exp_q[$];
  logic [7:0]  mosi_q[$], resp_q[$];
  logic [3:0]  sel_q[$];
  logic [1:0]  op_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic send(input logic [3:0] s, input logic [1:0] op, input logic [7:0] d, input logic [7:0] r);
    bit rdy;
    logic [7:0] e;
    @(negedge clk);
    cmd_sel = s; cmd_op = op; cmd_byte = d; cmd_valid = 1'b1;
    forever begin
      rdy = cmd_ready;
      @(posedge clk);
      if (rdy) break;
      waits++;
      @(negedge clk);
    end
    #1 cmd_valid = 1'b0;
    n_acc++;
    case (op)
      2'b00:   e = d;
      2'b11:   e = 8'h00;
      default: e = r;
    endcase
    exp_q.push_back({s, op, e});
    if (op != 2'b11) begin
      mosi_q.push_back(op == 2'b01 ? 8'h00 : d);
      sel_q.push_back(s);
      op_q.push_back(op);
      resp_q.push_back(r);
    end
  endtask

  // slave model: sample-edge capture and miso presentation
  int bitcnt = 0;
  logic [7:0] mo_sh = '0;
  always @(sclk) begin
    if (!rst && ss_n != '1 && sclk === ((CPOL == CPHA) ? 1'b1 : 1'b0)) begin
      mo_sh = {mo_sh[6:0], mosi};
      bitcnt++;
      if (bitcnt == 8) begin
        bitcnt = 0;
        if (mosi_q.size() == 0) chk(1'b0, "R2 spurious transfer", 1, 0);
        else begin
          // R5 R6 R7: mosi bits, MSB first
          chk(mo_sh == mosi_q[0], op_q[0] == 2'b01 ? "R6 mosi" : "R5 R7 mosi", mo_sh, mosi_q[0]);
          // R9: one-hot select of the commanded slave
          chk(ss_n == ~(16'd1 << sel_q[0]), "R9 select", ss_n, ~(16'd1 << sel_q[0]));
          void'(mosi_q.pop_front()); void'(sel_q.pop_front());
          void'(op_q.pop_front()); void'(resp_q.pop_front());
        end
      end
    end
  end

  always @(negedge clk) miso <= (resp_q.size() > 0) ? resp_q[0][7 - bitcnt] : 1'b0;

  // shape monitor: R8 R10 R11
  int hi_run = 0, ss_hi = 0, lead = 0;
  bit prev_hi = 1'b1, ever_low = 1'b0, armed = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (sclk == 1'b1) hi_run++;
      else if (hi_run > 0) begin
        chk(hi_run == HI, "R10 high phase", hi_run, HI);
        hi_run = 0;
      end
      if (&ss_n) begin
        if (!prev_hi) ss_rises++;
        ss_hi++;
      end else if (prev_hi) begin
        if (ever_low) chk(ss_hi >= P, "R8 R9 select gap", ss_hi, P);
        ever_low = 1'b1;
        lead = 0;
        armed = 1'b1;
      end
      if (&ss_n) ; else ss_hi = 0;
      if (armed) begin
        if (sclk != CPOL[0]) begin
          chk(lead >= LO, "R11 select lead", lead, LO);
          armed = 1'b0;
        end else lead++;
      end
      prev_hi = &ss_n;
    end
  end

  // result scoreboard: R2 R4 R5 R6 R7 R8
  always @(negedge clk) begin
    logic [13:0] got, e;
    res_ready = rr_hold ? 1'b0 : ((cyc % 4) != 1);
    if (!rst && res_valid && res_ready) begin
      got = {res_sel, res_op, res_data};
      if (exp_q.size() == 0) chk(1'b0, "R4 extra result", got, 0);
      else begin
        e = exp_q.pop_front();
        case (e[9:8])
          2'b00:   chk(got == e, "R2 R5 result", got, e);
          2'b01:   chk(got == e, "R2 R6 result", got, e);
          2'b10:   chk(got == e, "R2 R7 result", got, e);
          default: chk(got == e, "R2 R8 result", got, e);
        endcase
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    summary();
  end

  task automatic drain(input int target);
    for (int i = 0; i < 30000; i++) begin
      @(posedge clk);
      if (n_acc == target && exp_q.size() == 0 && mosi_q.size() == 0) break;
    end
    repeat (20) @(posedge clk);
  endtask

  initial begin
    int base;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: values during reset
    chk(ss_n == '1, "R1 ss_n", ss_n, 16'hffff);
    chk(sclk == CPOL[0], "R1 sclk", sclk, CPOL);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
    chk(ss_n == '1, "R1 ss_n after release", ss_n, 16'hffff);

    // phase 2: mixed ops, select hold, null and select changes
    send(4'd3,  2'b00, 8'hA5, 8'h3C);
    send(4'd3,  2'b00, 8'h5A, 8'hC3);
    send(4'd3,  2'b11, 8'hEE, 8'h00);
    send(4'd3,  2'b01, 8'h77, 8'h96);
    send(4'd5,  2'b10, 8'h81, 8'h7E);
    send(4'd15, 2'b10, 8'hFF, 8'h00);
    send(4'd0,  2'b01, 8'h12, 8'h01);
    drain(7);
    chk(ss_rises == 4, "R9 R8 select releases", ss_rises, 4);
    chk(waits > 0, "R3 command queue full", waits, 1);

    // phase 3: results held off, both queues fill
    @(posedge clk); rr_hold = 1'b1;
    base = n_acc;
    fork
      for (int i = 0; i < WD + RDP + 2; i++)
        send(4'd9, 2'(i % 3), 8'(8'h11 * i + 3), 8'(8'hC5 ^ (i * 7)));
    join_none
    repeat (3000) @(posedge clk);
    @(negedge clk);
    chk(n_acc - base == WD + RDP, "R3 accepted while stalled", n_acc - base, WD + RDP);
    chk(cmd_ready == 1'b0, "R3 cmd_ready stalled", cmd_ready, 0);
    chk(res_valid == 1'b1, "R4 result held", res_valid, 1);
    @(posedge clk); rr_hold = 1'b0;
    drain(base + WD + RDP + 2);
    chk(exp_q.size() == 0, "R4 all results", exp_q.size(), 0);
    summary();
  end
endmodule